// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block is the control sequencer that sits beside the fetch/decode/execute logic of a small CPU core. The execute stage pulses `exec_done` when an instruction retires. It also presents the address of the next instruction and tells the sequencer whether that instruction was an interrupt return or an enable/disable of interrupts. Only at that point does the sequencer look at the interrupt request. If the request is up and interrupts are enabled, it saves the flags, code segment and program counter on a descending stack. It then runs an acknowledge cycle to learn the requesting device's number, reads that device's 8-byte entry from a vector table, and resumes fetch at the handler.

All storage traffic goes through one request/ready memory bus, and every access may stall for any number of wait states. An interrupt return runs the opposite pops and restores the flags word bit for bit, which restores the privilege mode that was saved on entry. When the next fetch may start, the sequencer raises `fetch_go` for exactly one cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `pc_o` is 0, `cs_o` is 0, `sp_o` is `SP_RESET` (0x200), `flags_o` is `FLAGS_RESET` (0x1000: kernel bit 12 set, enable bit 9 clear), and `bus_req`, `inta` and `fetch_go` are low.
- R2: The request input is only looked at in the cycle where `exec_done` is high. A request held high while `exec_done` is low causes no bus access.
- R3: If `exec_done` arrives with a request but the enable bit (flags bit 9) is clear, no bus access takes place. `pc_o` takes `pc_next`, and `fetch_go` pulses.
- R4: Entry writes three 32-bit words, in this order: the flags to SP-4, the code segment to SP-8, and `pc_next` to SP-12. The stack pointer is decremented by 4 before each write and ends 12 lower than it started.
- R5: After the three writes, the sequencer makes one read with `inta` high. It takes the device number from `bus_rdata[7:0]`.
- R6: With j = `vt_base` + 8×id, the sequencer reads the word at j+4 first and presents it on `opt_o`. It then reads the word at j and loads that word into `pc_o`.
- R7: Entry pushes the old flags value, then clears the enable bit (9) and sets the kernel bit (12) in the live flags. All other flag bits keep their values.
- R8: An interrupt-return command reads the PC from SP, the code segment from SP+4 and the flags from SP+8. The stack pointer is incremented by 4 after each read. The popped flags are restored exactly, including the mode bit and the enable bit.
- R9: The disable and enable commands change bit 9 in the same cycle as `exec_done`, and the request check in that cycle already uses the new value. With enable and a request together, entry happens. With disable and a request together, no entry happens.
- R10: A bus request keeps its address, direction and write data steady until `bus_ready` is seen. Wait states do not change the sequence.
- R11: `fetch_go` is high for exactly one cycle. It comes in the cycle after the final bus access completes, or in the cycle after `exec_done` when no sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_done | input | 1 | Execute step of an instruction finished |
| pc_next | input | 32 | Address of the next instruction |
| cmd_iret | input | 1 | Retiring instruction is an interrupt return |
| cmd_cli | input | 1 | Retiring instruction disables interrupts |
| cmd_sti | input | 1 | Retiring instruction enables interrupts |
| irq | input | 1 | Interrupt request |
| vt_base | input | 32 | Vector table base register |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data or device number |
| bus_ready | input | 1 | Access completes this cycle |
| inta | output | 1 | Acknowledge cycle in progress |
| fetch_go | output | 1 | Next fetch may begin |
| pc_o | output | 32 | Program counter |
| cs_o | output | 32 | Code segment |
| flags_o | output | 32 | Flags word |
| sp_o | output | 32 | Stack pointer |
| opt_o | output | 32 | Last vector options word |

## Verification
A wrong state step would show up on the bus within one access. The bench would see a frame word at the wrong stack slot, the acknowledge out of place, or the options and handler reads at swapped or shifted addresses. A wrong stack pointer or flags update cannot hide, because the following interrupt return reads the frame back. That return must leave `pc_o`, `cs_o`, `flags_o` and `sp_o` exactly as they were before entry, at the `fetch_go` pulse a few cycles later. Every device number in the table is swept with zero to two wait states, so address arithmetic errors in the vector index would surface on the first affected entry.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int DW          = 32,
  parameter int ID_W        = 8,
  parameter int IE_BIT      = 9,
  parameter int KM_BIT      = 12,
  parameter logic [31:0] SP_RESET    = 32'h0000_0200,
  parameter logic [31:0] FLAGS_RESET = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_done,
  input  logic [DW-1:0] pc_next,
  input  logic          cmd_iret,
  input  logic          cmd_cli,
  input  logic          cmd_sti,
  input  logic          irq,
  input  logic [DW-1:0] vt_base,
  output logic          bus_req,
  output logic          bus_we,
  output logic [DW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready,
  output logic          inta,
  output logic          fetch_go,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] cs_o,
  output logic [DW-1:0] flags_o,
  output logic [DW-1:0] sp_o,
  output logic [DW-1:0] opt_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);
  localparam logic [DW-1:0] VSZ  = STEP * 2;

  typedef enum logic [3:0] {
    S_IDLE, S_PSH_F, S_PSH_CS, S_PSH_PC, S_ACK,
    S_OPT, S_VEC, S_POP_PC, S_POP_CS, S_POP_F, S_DONE
  } st_t;

  st_t           state;
  logic [DW-1:0] vaddr;
  logic [DW-1:0] flags_eff;
  logic          pushing, popping;

  always_comb begin
    flags_eff = flags_o;
    if (cmd_cli) flags_eff[IE_BIT] = 1'b0;
    if (cmd_sti) flags_eff[IE_BIT] = 1'b1;
  end

  assign pushing  = (state == S_PSH_F) || (state == S_PSH_CS) || (state == S_PSH_PC);
  assign popping  = (state == S_POP_PC) || (state == S_POP_CS) || (state == S_POP_F);
  assign inta     = (state == S_ACK);
  assign bus_req  = pushing || popping || inta || (state == S_OPT) || (state == S_VEC);
  assign bus_we   = pushing;
  assign fetch_go = (state == S_DONE);

  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    case (state)
      S_PSH_F:  begin bus_addr = sp_o - STEP; bus_wdata = flags_o; end
      S_PSH_CS: begin bus_addr = sp_o - STEP; bus_wdata = cs_o;    end
      S_PSH_PC: begin bus_addr = sp_o - STEP; bus_wdata = pc_o;    end
      S_OPT:    bus_addr = vaddr + STEP;
      S_VEC:    bus_addr = vaddr;
      S_POP_PC, S_POP_CS, S_POP_F: bus_addr = sp_o;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pc_o    <= '0;
      cs_o    <= '0;
      flags_o <= FLAGS_RESET;
      sp_o    <= SP_RESET;
      opt_o   <= '0;
      vaddr   <= '0;
    end else begin
      case (state)
        S_IDLE: if (exec_done) begin
          if (cmd_iret) state <= S_POP_PC;
          else begin
            pc_o    <= pc_next;
            flags_o <= flags_eff;
            state   <= (irq && flags_eff[IE_BIT]) ? S_PSH_F : S_DONE;
          end
        end
        S_PSH_F: if (bus_ready) begin
          sp_o            <= sp_o - STEP;
          flags_o[IE_BIT] <= 1'b0;
          flags_o[KM_BIT] <= 1'b1;
          state           <= S_PSH_CS;
        end
        S_PSH_CS: if (bus_ready) begin
          sp_o  <= sp_o - STEP;
          state <= S_PSH_PC;
        end
        S_PSH_PC: if (bus_ready) begin
          sp_o  <= sp_o - STEP;
          state <= S_ACK;
        end
        S_ACK: if (bus_ready) begin
          vaddr <= vt_base + VSZ * DW'(bus_rdata[ID_W-1:0]);
          state <= S_OPT;
        end
        S_OPT: if (bus_ready) begin
          opt_o <= bus_rdata;
          state <= S_VEC;
        end
        S_VEC: if (bus_ready) begin
          pc_o  <= bus_rdata;
          state <= S_DONE;
        end
        S_POP_PC: if (bus_ready) begin
          pc_o  <= bus_rdata;
          sp_o  <= sp_o + STEP;
          state <= S_POP_CS;
        end
        S_POP_CS: if (bus_ready) begin
          cs_o  <= bus_rdata;
          sp_o  <= sp_o + STEP;
          state <= S_POP_F;
        end
        S_POP_F: if (bus_ready) begin
          flags_o <= bus_rdata;
          sp_o    <= sp_o + STEP;
          state   <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
  // R5
  inta_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> bus_req && !bus_we);
  // R11
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> !fetch_go);
  // R7
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inta |-> !flags_o[IE_BIT] && flags_o[KM_BIT]);
  // R4
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ready |=> sp_o == $past(sp_o) - STEP);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) && !exec_done |=> !bus_req);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        exec_done = 0, cmd_iret = 0, cmd_cli = 0, cmd_sti = 0, irq = 0;
  logic [31:0] pc_next = 0, vt_base = 32'h100, bus_rdata = 0;
  logic        bus_ready = 0;
  logic        bus_req, bus_we, inta, fetch_go;
  logic [31:0] bus_addr, bus_wdata, pc_o, cs_o, flags_o, sp_o, opt_o;

  int tests = 0, fails = 0, ws = 0, wc = 0, nlog = 0;
  logic [31:0] mem [256];
  logic [31:0] la [16];
  logic [31:0] ld [16];
  logic        lw [16];
  logic        li [16];
  logic [7:0]  ack_id = 0;

  always #4 clk = ~clk;

  irq_entry_seq dut_i (.*);

  always @(negedge clk) begin
    if (bus_ready) begin
      bus_ready = 0; wc = 0;
    end else if (bus_req) begin
      if (wc >= ws) begin
        bus_ready = 1;
        bus_rdata = inta ? {24'h0, ack_id} : mem[bus_addr[9:2]];
        if (bus_we) mem[bus_addr[9:2]] = bus_wdata;
        if (nlog < 16) begin
          la[nlog] = bus_addr; ld[nlog] = bus_we ? bus_wdata : bus_rdata;
          lw[nlog] = bus_we; li[nlog] = inta;
        end
        nlog++;
      end else wc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic instr(input logic [31:0] pn, input bit rq, input bit ir, input bit cl, input bit st);
    int n = 0;
    nlog = 0;
    @(negedge clk);
    exec_done = 1; pc_next = pn; irq = rq; cmd_iret = ir; cmd_cli = cl; cmd_sti = st;
    @(negedge clk);
    exec_done = 0; cmd_iret = 0; cmd_cli = 0; cmd_sti = 0;
    while (!fetch_go && n < 200) begin @(negedge clk); n++; end
    chk(n < 200, "R11 fetch_go timeout", 32'(n), 0);
    @(negedge clk);
    chk(!fetch_go, "R11 single pulse", {31'b0, fetch_go}, 0);
    irq = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + 32'(i);
    for (int k = 0; k < 8; k++) begin
      mem[(32'h100 + 8 * k) >> 2]     = 32'h4000 + 32'(k) * 32'h10;
      mem[(32'h100 + 8 * k + 4) >> 2] = 32'hA0 + 32'(k);
    end
    mem[32'h200 >> 2] = 32'h3000;
    mem[32'h204 >> 2] = 32'h0008;
    mem[32'h208 >> 2] = 32'h0200;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(pc_o == 0 && cs_o == 0, "R1 pc/cs", pc_o, 0);
    chk(sp_o == 32'h200, "R1 sp", sp_o, 32'h200);
    chk(flags_o == 32'h1000, "R1 flags", flags_o, 32'h1000);
    chk(!bus_req && !inta && !fetch_go, "R1 outputs idle", {bus_req, inta, fetch_go}, 0);

    nlog = 0; irq = 1;
    repeat (10) @(negedge clk);
    chk(nlog == 0, "R2 no access without exec_done", 32'(nlog), 0);
    irq = 0;

    instr(32'h50, 1, 0, 0, 0);
    chk(nlog == 0, "R3 disabled no access", 32'(nlog), 0);
    chk(pc_o == 32'h50, "R3 pc takes next", pc_o, 32'h50);

    instr(0, 0, 1, 0, 0);
    chk(nlog == 3 && la[0] == 32'h200 && la[1] == 32'h204 && la[2] == 32'h208,
        "R8 pop addresses", la[2], 32'h208);
    chk(pc_o == 32'h3000 && cs_o == 8, "R8 pc/cs restored", pc_o, 32'h3000);
    chk(flags_o == 32'h0200, "R8 flags exact", flags_o, 32'h0200);
    chk(sp_o == 32'h20C, "R8 sp", sp_o, 32'h20C);

    for (int w = 0; w < 3; w++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] pn, j;
        ws = w; ack_id = 8'(k);
        pn = 32'h5000 + 32'(w * 64 + k * 4);
        j = 32'h100 + 32'(8 * k);
        instr(pn, 1, 0, 0, 0);
        chk(nlog == 6, "R4 access count", 32'(nlog), 6);
        chk(lw[0] && la[0] == 32'h208 && ld[0] == 32'h0200, "R4 flags push", la[0], 32'h208);
        chk(lw[1] && la[1] == 32'h204 && ld[1] == 32'h8, "R4 cs push", la[1], 32'h204);
        chk(lw[2] && la[2] == 32'h200 && ld[2] == pn, "R4 pc push", ld[2], pn);
        chk(li[3] && !lw[3], "R5 ack cycle", {31'b0, li[3]}, 1);
        chk(!li[4] && la[4] == j + 4 && la[5] == j, "R6 vector order", la[4], j + 4);
        chk(pc_o == 32'h4000 + 32'(k) * 32'h10, "R6 handler pc", pc_o, 32'h4000 + 32'(k) * 32'h10);
        chk(opt_o == 32'hA0 + 32'(k), "R6 options", opt_o, 32'hA0 + 32'(k));
        chk(flags_o == 32'h1000, "R7 live flags", flags_o, 32'h1000);
        chk(sp_o == 32'h200, "R4 sp after entry", sp_o, 32'h200);
        instr(0, 0, 1, 0, 0);
        chk(pc_o == pn && cs_o == 8, "R8 return pc", pc_o, pn);
        chk(flags_o == 32'h0200 && sp_o == 32'h20C, "R8 flags/sp", flags_o, 32'h0200);
        chk(nlog == 3, "R10 pop count with waits", 32'(nlog), 3);
      end
    end

    ws = 1;
    instr(32'h60, 1, 0, 1, 0);
    chk(nlog == 0 && flags_o == 32'h0000, "R9 disable gates same cycle", flags_o, 0);
    ack_id = 2;
    instr(32'h64, 1, 0, 0, 1);
    chk(nlog == 6 && pc_o == 32'h4020, "R9 enable allows entry", pc_o, 32'h4020);
    chk(mem[32'h208 >> 2] == 32'h0200, "R9 pushed flags enabled", mem[32'h208 >> 2], 32'h0200);
    chk(flags_o == 32'h1000, "R7 other bits kept", flags_o, 32'h1000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule